// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Bank

This block sits beside the sequencer of a serial encoder interface and keeps the record of what happened during each transfer. The sequencer reports events, errors and received words as one-cycle pulses. The bank latches each event into a status bit. The bit stays set until software writes a one to its position. Software also writes an enable mask with the same layout. When any enabled status bit is set, the block drives a shared active-low interrupt line; otherwise it leaves the line released.

Each receive data register has its own "updated" bit. While that bit is set, the register belongs to software, and the sequencer cannot overwrite it unless the unconditional-transfer option is on. If automatic clearing is enabled, the error and event bits are wiped when the sequencer signals the start of the next reception. Three bits at the top of the word mirror live engine state: delay measured, compensation active, and ready for the next transfer. Software cannot clear these three bits, and they never raise an interrupt.

Top module: `evt_status_bank`

## Requirements
- R1: A sticky status bit stays set until a write with `reg_sel`=0 carries a 1 at that bit position. A written 0 leaves the bit unchanged. With the default parameters, the event bits are stat_q[15:8] (event k at bit 8+k).
- R2: When a hardware set pulse and a software write-1 clear hit the same bit in the same cycle, the bit ends set.
- R3: The mask is written with `reg_sel`=1 and uses the status layout. A 1 enables that source. `irq_oe` is 1 on the cycle after some status bit and its mask bit are both 1, and is 0 otherwise. `irq_o` is always 0.
- R4: The live bits stat_q[16] (measured), stat_q[17] (compensation active) and stat_q[18] (ready) show `live_meas`, `live_comp` and `live_ready` one cycle after those inputs. They ignore write-1 clears and never cause `irq_oe`, even when masked in.
- R5: Receive register r (`rx_q` slice r, DATA_W bits) takes `rx_wdata` slice r when `rx_wr[r]` pulses, and sets updated bit stat_q[r]. While stat_q[r] is 1, further writes are dropped.
- R6: With `cfg_uncond` at 1, a receive write is accepted even when its updated bit is set, and the updated bit stays 1.
- R7: With `cfg_auto_clr` at 1, an `rx_start` pulse clears the error bits stat_q[7:3] and the event bits. The updated bits and the live bits are untouched. With `cfg_auto_clr` at 0, `rx_start` has no effect.
- R8: The error bits are laid out as follows: `err_set`[0] general → stat_q[3]; [1] check fail → stat_q[4]; [2] type-one → stat_q[5]; [3] type-two → stat_q[6]; [4] address/acknowledge → stat_q[7]. A type-one or type-two error also sets stat_q[7].
- R9: A synchronous `rst` clears every sticky bit, the whole mask and `irq_oe`.
- R10: A hardware set in the same cycle as an automatic clear leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_uncond | input | 1 | Accept receive writes regardless of updated bits |
| cfg_auto_clr | input | 1 | Clear errors and events when reception starts |
| rx_wr | input | N_RX | Per-register receive write pulse |
| rx_wdata | input | N_RX*DATA_W | Receive data, register r in slice r |
| rx_start | input | 1 | Pulse at start of data reception |
| err_set | input | 5 | Error set pulses |
| evt_set | input | N_EVT | Event set pulses |
| live_meas | input | 1 | Live: delay measurement complete |
| live_comp | input | 1 | Live: compensation active |
| live_ready | input | 1 | Live: ready for next transfer |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status clear, 1 = mask |
| reg_wdata | input | STAT_W | Write data |
| stat_q | output | STAT_W | Status word |
| rx_q | output | N_RX*DATA_W | Receive registers |
| irq_oe | output | 1 | Interrupt drive enable (line pulled low when 1) |
| irq_o | output | 1 | Interrupt data, constant 0 |

## Verification
The bench builds the block with three receive registers, eight events and DATA_W reduced to 16. This gives a 19-bit status word, so every bit position can be set, cleared and masked one at a time. The shorter data width keeps the blocked-write and overwrite cases easy to tell apart by distinct patterns. With the event count at eight, a table of set/clear pairs covers all eight event bits. That table includes same-cycle conflicts and plain write-zero attempts.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;
  localparam int ERR_W  = 5;
  localparam int LIVE_W = 3;
  localparam int E_GEN  = 0;
  localparam int E_CHK  = 1;
  localparam int E_T1   = 2;
  localparam int E_T2   = 3;
  localparam int E_ADDR = 4;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int STICKY_W = 16,
  parameter int LIVE_W   = 3,
  localparam int STAT_W  = STICKY_W + LIVE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STICKY_W-1:0] set_i,
  input  logic [STICKY_W-1:0] clr_i,
  input  logic [STICKY_W-1:0] auto_i,
  input  logic [LIVE_W-1:0]   live_i,
  output logic [STAT_W-1:0]   q_o
);
  for (genvar i = 0; i < STICKY_W; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst) q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i] || auto_i[i]) q_o[i] <= 1'b0;
    end
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (q_o[i] && !clr_i[i] && !auto_i[i]) |=> q_o[i]); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> q_o[i]); // R2
  end

  for (genvar j = 0; j < LIVE_W; j++) begin : g_live
    always_ff @(posedge clk) begin
      if (rst) q_o[STICKY_W+j] <= 1'b0;
      else     q_o[STICKY_W+j] <= live_i[j];
    end
    AST_LIVE_TRACK: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (q_o[STICKY_W+j] == $past(live_i[j]))); // R4
  end
endmodule

// File: rtl/evt_rx_hold.sv
module evt_rx_hold #(
  parameter int N_RX   = 3,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_RX-1:0]        wr_i,
  input  logic [N_RX*DATA_W-1:0] data_i,
  input  logic [N_RX-1:0]        held_i,
  input  logic                   uncond_i,
  output logic [N_RX-1:0]        acc_o,
  output logic [N_RX*DATA_W-1:0] q_o
);
  always_comb acc_o = wr_i & (~held_i | {N_RX{uncond_i}});

  for (genvar r = 0; r < N_RX; r++) begin : g_rx
    always_ff @(posedge clk) begin
      if (rst) q_o[r*DATA_W +: DATA_W] <= '0;
      else if (acc_o[r]) q_o[r*DATA_W +: DATA_W] <= data_i[r*DATA_W +: DATA_W];
    end
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (held_i[r] && !uncond_i) |=> $stable(q_o[r*DATA_W +: DATA_W])); // R5
  end
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl #(
  parameter int STAT_W = 19,
  parameter int LIVE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              irq_oe_o,
  output logic              irq_o
);
  localparam logic [STAT_W-1:0] IRQ_OK = {{LIVE_W{1'b0}}, {(STAT_W-LIVE_W){1'b1}}};
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_oe_o <= 1'b0;
    else     irq_oe_o <= |(stat_i & mask_q & IRQ_OK);
  end

  assign irq_o = 1'b0;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_oe_o |-> $past(|(stat_i[STAT_W-LIVE_W-1:0] & mask_q[STAT_W-LIVE_W-1:0]))); // R3
  AST_IRQ_NO_LIVE: assert property (@(posedge clk) disable iff (rst)
    $past(stat_i[STAT_W-LIVE_W-1:0] == '0) |-> !irq_oe_o); // R4
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_stat_pkg::*;
#(
  parameter int N_RX    = 3,
  parameter int DATA_W  = 32,
  parameter int N_EVT   = 8,
  localparam int STICKY_W = N_RX + ERR_W + N_EVT,
  localparam int STAT_W   = STICKY_W + LIVE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_uncond,
  input  logic                   cfg_auto_clr,
  input  logic [N_RX-1:0]        rx_wr,
  input  logic [N_RX*DATA_W-1:0] rx_wdata,
  input  logic                   rx_start,
  input  logic [ERR_W-1:0]       err_set,
  input  logic [N_EVT-1:0]       evt_set,
  input  logic                   live_meas,
  input  logic                   live_comp,
  input  logic                   live_ready,
  input  logic                   reg_we,
  input  logic                   reg_sel,
  input  logic [STAT_W-1:0]      reg_wdata,
  output logic [STAT_W-1:0]      stat_q,
  output logic [N_RX*DATA_W-1:0] rx_q,
  output logic                   irq_oe,
  output logic                   irq_o
);
  localparam int ERR_LO = N_RX;
  localparam logic [STICKY_W-1:0] AUTO_MASK = {{(ERR_W+N_EVT){1'b1}}, {N_RX{1'b0}}};

  logic [N_RX-1:0]     rx_acc;
  logic [ERR_W-1:0]    err_vec;
  logic [STICKY_W-1:0] hw_set, sw_clr, auto_clr;

  always_comb begin
    err_vec         = err_set;
    err_vec[E_ADDR] = err_set[E_ADDR] | err_set[E_T1] | err_set[E_T2];
    hw_set   = {evt_set, err_vec, rx_acc};
    sw_clr   = (reg_we && reg_sel == SEL_STATUS) ? reg_wdata[STICKY_W-1:0] : '0;
    auto_clr = (rx_start && cfg_auto_clr) ? AUTO_MASK : '0;
  end

  evt_rx_hold #(.N_RX(N_RX), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .wr_i(rx_wr), .data_i(rx_wdata),
    .held_i(stat_q[N_RX-1:0]), .uncond_i(cfg_uncond),
    .acc_o(rx_acc), .q_o(rx_q)
  );

  evt_sticky_bank #(.STICKY_W(STICKY_W), .LIVE_W(LIVE_W)) u_sticky (
    .clk(clk), .rst(rst), .set_i(hw_set), .clr_i(sw_clr), .auto_i(auto_clr),
    .live_i({live_ready, live_comp, live_meas}), .q_o(stat_q)
  );

  evt_irq_ctl #(.STAT_W(STAT_W), .LIVE_W(LIVE_W)) u_irq (
    .clk(clk), .rst(rst), .mask_we_i(reg_we && reg_sel == SEL_MASK),
    .wdata_i(reg_wdata), .stat_i(stat_q), .irq_oe_o(irq_oe), .irq_o(irq_o)
  );

  AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (err_set[E_T1] || err_set[E_T2]) |=> stat_q[ERR_LO+E_ADDR]); // R8
  AST_AUTO_KEEPS_RX: assert property (@(posedge clk) disable iff (rst)
    (rx_start && cfg_auto_clr && !reg_we && stat_q[0]) |=> stat_q[0]); // R7
endmodule

// File: tb/tb_evt_status_bank.sv
module tb_evt_status_bank;
  localparam int N_RX = 3, DATA_W = 16, N_EVT = 8, SW = 19;
  logic clk = 0, rst = 1;
  logic cfg_uncond = 0, cfg_auto_clr = 0, rx_start = 0;
  logic [N_RX-1:0] rx_wr = '0;
  logic [N_RX*DATA_W-1:0] rx_wdata = '0;
  logic [4:0] err_set = '0;
  logic [N_EVT-1:0] evt_set = '0;
  logic live_meas = 0, live_comp = 0, live_ready = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [SW-1:0] reg_wdata = '0;
  logic [SW-1:0] stat_q;
  logic [N_RX*DATA_W-1:0] rx_q;
  logic irq_oe, irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_status_bank #(.N_RX(N_RX), .DATA_W(DATA_W), .N_EVT(N_EVT)) dut (.*);

  // {event set, event-field write data, expected events}
  localparam logic [23:0] VEC [10] = '{
    24'h01_00_01, 24'h00_00_01, 24'h82_01_82, 24'h00_80_02, 24'h02_02_02,
    24'h40_FF_40, 24'h00_40_00, 24'hFF_00_FF, 24'h00_0F_F0, 24'h00_F0_00};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    rx_wr = '0; rx_start = 0; err_set = '0; evt_set = '0; reg_we = 0;
  endtask

  task automatic wr(input logic sel, input logic [SW-1:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R9 reset status", stat_q, 0);
    chk("R9 reset irq", irq_oe, 0);
    chk("R3 irq data", irq_o, 0);
    rst = 0;

    // R1 R2 table walk
    for (int k = 0; k < 10; k++) begin
      evt_set = VEC[k][23:16];
      wr(1'b0, {3'b0, VEC[k][15:8], 8'h00});
      cyc();
      chk($sformatf("R1/R2 vector %0d", k), stat_q[15:8], VEC[k][7:0]);
    end

    // R8 error mapping
    err_set = 5'b00100; cyc();
    chk("R8 type-one", stat_q[7:3], 5'b10100);
    wr(0, '1); cyc();
    err_set = 5'b01000; cyc();
    chk("R8 type-two", stat_q[7:3], 5'b11000);
    wr(0, '1); cyc();
    err_set = 5'b10000; cyc();
    chk("R8 addr only", stat_q[7:3], 5'b10000);
    wr(0, '1); cyc();

    // R3 interrupt masking
    wr(1, 19'h00200); cyc();
    evt_set = 8'h04; cyc(); cyc();
    chk("R3 unmasked source", irq_oe, 0);
    evt_set = 8'h02; cyc();
    chk("R3 one cycle later", irq_oe, 0);
    cyc();
    chk("R3 masked source drives", irq_oe, 1);
    chk("R3 data low", irq_o, 0);
    wr(0, 19'h00200); cyc(); cyc();
    chk("R3 released after clear", irq_oe, 0);
    wr(0, '1); cyc();

    // R4 live bits
    wr(1, '1); live_meas = 1; live_comp = 1; live_ready = 1; cyc();
    chk("R4 live follow", stat_q[18:16], 3'b111);
    wr(0, '1); cyc(); cyc();
    chk("R4 live ignores clear", stat_q[18:16], 3'b111);
    chk("R4 live no irq", irq_oe, 0);
    live_meas = 0; live_ready = 0; cyc();
    chk("R4 live drop", stat_q[18:16], 3'b010);
    live_comp = 0; wr(1, '0); cyc();

    // R5 blocking
    rx_wr = 3'b001; rx_wdata[15:0] = 16'hA5A5; cyc();
    chk("R5 first write", rx_q[15:0], 16'hA5A5);
    chk("R5 updated bit", stat_q[0], 1);
    rx_wr = 3'b001; rx_wdata[15:0] = 16'h1234; cyc();
    chk("R5 blocked write", rx_q[15:0], 16'hA5A5);
    wr(0, 19'h1); cyc();
    rx_wr = 3'b001; rx_wdata[15:0] = 16'h0F0F; cyc();
    chk("R5 after release", rx_q[15:0], 16'h0F0F);

    // R6 unconditional
    cfg_uncond = 1; rx_wr = 3'b101; rx_wdata = {16'hC3C3, 16'h0, 16'h7777}; cyc();
    chk("R6 overwrite", rx_q[15:0], 16'h7777);
    chk("R6 other reg", rx_q[47:32], 16'hC3C3);
    chk("R6 flags kept", stat_q[2:0], 3'b101);
    cfg_uncond = 0;

    // R7 auto clear
    err_set = 5'b00011; evt_set = 8'h81; cyc();
    rx_start = 1; cyc();
    chk("R7 disabled no effect", stat_q[15:0], 16'h811D);
    cfg_auto_clr = 1; rx_start = 1; cyc();
    chk("R7 auto clear", stat_q[15:0], 16'h0005);

    // R10 set beats auto clear
    evt_set = 8'h01; cyc();
    rx_start = 1; evt_set = 8'h08; cyc();
    chk("R10 set wins auto", stat_q[15:8], 8'h08);
    cfg_auto_clr = 0;

    // R9 reset mid-run
    wr(1, '1); cyc();
    rst = 1; cyc(); rst = 0;
    chk("R9 status cleared", stat_q, 0);
    chk("R9 rx cleared", rx_q, 0);
    evt_set = 8'h10; cyc(); cyc();
    chk("R9 mask cleared", irq_oe, 0);

    done = 1;
    finish_run();
  end
endmodule